// File: doc/BRIEF.md
# Alternating 5/6 Cadence Clock Enable Generator

This block derives a one-cycle clock enable from a fast system clock, with pulses spaced alternately 5 and 6 clocks apart. The mean spacing is therefore 5.5 clocks, so a 148.5 MHz clock yields a 27 MHz word rate. That is the rate a standard-definition serial video transmitter needs on its 10-bit word input. Each pulse marks the one cycle in which the transmitter takes a word from its data input.

Two copies of the cadence enable are driven, and they assert on the same cycles. One goes to the word-accept input. The other goes to the error-detection checkword inserter. A third enable output stays high for the transmitter's high-rate enable port. A phase flag shows whether the gap now running is the 5-cycle or the 6-cycle one, so downstream logic can align to the pattern. A run input starts the cadence. While run is low the enables stay quiet and the pattern restarts from its short phase.

Top module: `cadence_ce_gen`

## Requirements
- R1: With rst_n and run high and the sequence at its start (the first cycle after reset is released, or the first cycle run is high again), word_ce is high in that same cycle.
- R2: Counted between the cycles in which word_ce is high, successive pulses are 5, 6, 5, 6 ... clocks apart with no deviation. The first gap after a start is 5.
- R3: Every word_ce pulse is exactly one clock cycle wide.
- R4: edh_ce equals word_ce in every cycle.
- R5: hd_ce is high in every cycle.
- R6: long_gap is 1 from a pulse that opens a 6-cycle gap through the cycle before the next pulse, and 0 during 5-cycle gaps. It changes value only in a cycle where word_ce is high, except when run or reset forces it back to 0.
- R7: While run is low, word_ce and edh_ce are low in that same cycle. After one clock edge with run low, long_gap is 0, and the next run-high cycle behaves as a fresh start (R1, R2).
- R8: While rst_n is low, word_ce and edh_ce are low. After the first clock edge in reset, long_gap is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 148.5 MHz in the target use |
| rst_n | input | 1 | Synchronous reset, active low |
| run | input | 1 | Cadence enable; low holds the outputs quiet and rewinds the pattern |
| word_ce | output | 1 | One-cycle word-accept enable on the 5/6 cadence |
| edh_ce | output | 1 | Copy of word_ce for the checkword inserter |
| hd_ce | output | 1 | Constant-high enable for the high-rate enable port |
| long_gap | output | 1 | 1 while the current gap is the 6-cycle one |

## Verification
The enables depend combinationally on run and reset and on registered state. A change of run or rst_n therefore shows on word_ce and edh_ce in the same cycle, and the rewind of long_gap and of the count shows one edge later. The bench drives inputs on the falling edge and samples 1 ns later, so each table row and each directed step tests the cycle just driven. Gap lengths are measured by subtracting the cycle indices of successive pulses, and each is compared with an alternating expected value that restarts at 5 after every start.

// File: rtl/cce_pkg.sv
// Package: shared definitions for the cadence enable generator.
// Assumes: the gap pattern is two lengths that differ by one.
package cce_pkg;
    typedef enum logic {
        GAP_SHORT = 1'b0,
        GAP_LONG  = 1'b1
    } gap_phase_e;
endpackage

// File: rtl/cce_gap_counter.sv
// Module: counts clocks inside the current gap and flags its last cycle.
// Assumes: phase selects the length of the current gap; run low rewinds the count.
module cce_gap_counter #(
    parameter int SHORT_GAP = 5,
    parameter int CNT_W     = $clog2(SHORT_GAP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  cce_pkg::gap_phase_e phase,
    output logic              at_start,
    output logic              wrap
);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SHORT_GAP - 1);
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(SHORT_GAP);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_idx;

    // Pick the final count value of the gap now running.
    always_comb begin
        last_idx = (phase == cce_pkg::GAP_LONG) ? LAST_LONG : LAST_SHORT;
    end

    assign at_start = (cnt_q == '0);
    assign wrap     = run && (cnt_q == last_idx);

    // Advance the count, or rewind it on reset, on run low, or at the end of a gap.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/cce_phase_tracker.sv
// Module: holds which gap length is running; flips at every gap end.
// Assumes: wrap is a one-cycle strobe on the last cycle of a gap.
module cce_phase_tracker (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                wrap,
    output cce_pkg::gap_phase_e phase
);
    // Swap between short and long gaps; rewind to short on reset or stop.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase <= cce_pkg::GAP_SHORT;
        end else if (wrap) begin
            phase <= (phase == cce_pkg::GAP_LONG) ? cce_pkg::GAP_SHORT : cce_pkg::GAP_LONG;
        end
    end
endmodule

// File: rtl/cadence_ce_gen.sv
// Module: top of the 5/6 cadence enable generator.
// Assumes: clk is the fast word clock; rst_n is synchronous and active low.
// Enables are gated by run and rst_n in the same cycle.
module cadence_ce_gen #(
    parameter int SHORT_GAP = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic word_ce,
    output logic edh_ce,
    output logic hd_ce,
    output logic long_gap
);
    localparam int LONG_GAP = SHORT_GAP + 1;
    localparam int CNT_W    = $clog2(LONG_GAP);
    localparam int MON_W    = $clog2(LONG_GAP + 2);

    cce_pkg::gap_phase_e phase;
    logic at_start;
    logic wrap;
    logic ce_int;

    cce_gap_counter #(.SHORT_GAP(SHORT_GAP), .CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .run(run), .phase(phase),
        .at_start(at_start), .wrap(wrap)
    );

    cce_phase_tracker u_phase (
        .clk(clk), .rst_n(rst_n), .run(run), .wrap(wrap), .phase(phase)
    );

    // Pulse only at the start of a gap while running and out of reset.
    always_comb begin
        ce_int = rst_n && run && at_start;
    end

    assign word_ce  = ce_int;
    assign edh_ce   = ce_int;
    assign hd_ce    = 1'b1;
    assign long_gap = (phase == cce_pkg::GAP_LONG);

    // Monitor: clocks since the last pulse, and the phase that pulse opened.
    logic [MON_W-1:0] since_q;
    logic             armed_q;
    logic             prev_long_q;

    // Track the distance between pulses for the gap check.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            since_q     <= '0;
            armed_q     <= 1'b0;
            prev_long_q <= 1'b0;
        end else if (word_ce) begin
            since_q     <= MON_W'(1);
            armed_q     <= 1'b1;
            prev_long_q <= long_gap;
        end else if (since_q != '1) begin
            since_q <= since_q + 1'b1;
        end
    end

    assert_gap_alternates_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (word_ce && armed_q) |-> (since_q == (prev_long_q ? MON_W'(LONG_GAP) : MON_W'(SHORT_GAP))));

    assert_single_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        word_ce |=> !word_ce);

    assert_first_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && run) |-> word_ce);

    assert_restart_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!run) && run) |-> (word_ce && !long_gap));

    assert_phase_moves_on_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && $past(rst_n) && (long_gap != $past(long_gap))) |-> word_ce);
endmodule

// File: tb/cadence_ce_gen_bench.sv
module cadence_ce_gen_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0;
    logic word_ce, edh_ce, hd_ce, long_gap;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    cadence_ce_gen u_cadence_ce_gen (
        .clk(clk), .rst_n(rst_n), .run(run),
        .word_ce(word_ce), .edh_ce(edh_ce), .hd_ce(hd_ce), .long_gap(long_gap)
    );

    // Row: {run driven, expected word_ce, expected long_gap}, one per cycle.
    localparam logic [2:0] VEC [36] = '{
        3'b110, 3'b100, 3'b100, 3'b100, 3'b100,
        3'b111, 3'b101, 3'b101, 3'b101, 3'b101, 3'b101,
        3'b110, 3'b100, 3'b100, 3'b100, 3'b100,
        3'b111, 3'b101, 3'b101, 3'b101, 3'b101, 3'b101,
        3'b110, 3'b100, 3'b100, 3'b100, 3'b100,
        3'b111,
        3'b001, 3'b000,
        3'b110, 3'b100, 3'b100, 3'b100, 3'b100,
        3'b111
    };

    task automatic check(input string req, input logic act, input logic exp, input int idx);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s step %0d: actual %b expected %b", req, idx, act, exp);
        end
    endtask

    task automatic step;
        @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R8: reset with run high keeps the enables quiet.
        run = 1'b1;
        repeat (3) step();
        #1;
        check("R8 word_ce in reset", word_ce, 1'b0, -1);
        check("R8 edh_ce in reset", edh_ce, 1'b0, -1);
        check("R8 long_gap in reset", long_gap, 1'b0, -1);
        check("R5 hd_ce in reset", hd_ce, 1'b1, -1);

        // Table walk: R1 first pulse, R2 gaps, R6 phase, R7 stop/restart.
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 36; i++) begin
            run = VEC[i][2];
            #1;
            check("R1/R2/R7 word_ce", word_ce, VEC[i][1], i);
            check("R6 long_gap", long_gap, VEC[i][0], i);
            check("R4 edh_ce", edh_ce, word_ce, i);
            @(negedge clk);
        end

        // Directed: reset in mid-pattern, then R1 fresh start.
        rst_n = 1'b0;
        #1;
        check("R8 word_ce mid reset", word_ce, 1'b0, 100);
        step();
        #1;
        check("R8 long_gap after reset edge", long_gap, 1'b0, 101);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 pulse after reset release", word_ce, 1'b1, 102);

        // Long run: R2 alternation, R3 width, R4 copy, R5 constant.
        begin
            int last = 0;
            int want = 5;
            logic prev = 1'b1;
            int bad3 = 0, bad4 = 0, bad5 = 0;
            @(negedge clk);
            for (int c = 1; c < 400; c++) begin
                #1;
                if (word_ce) begin
                    check("R2 gap length", (c - last) == want, 1'b1, c);
                    if ((c - last) != want)
                        $display("FAIL R2 gap actual %0d expected %0d", c - last, want);
                    last = c;
                    want = (want == 5) ? 6 : 5;
                end
                if (prev && word_ce) bad3++;
                if (edh_ce !== word_ce) bad4++;
                if (hd_ce !== 1'b1) bad5++;
                prev = word_ce;
                @(negedge clk);
            end
            check("R3 no double pulse", bad3 == 0, 1'b1, 500);
            check("R4 edh_ce copy", bad4 == 0, 1'b1, 501);
            check("R5 hd_ce high", bad5 == 0, 1'b1, 502);
        end

        // R7: run low holds enables low for many cycles.
        run = 1'b0;
        begin
            int hits = 0;
            for (int k = 0; k < 20; k++) begin
                #1;
                if (word_ce || edh_ce) hits++;
                @(negedge clk);
            end
            check("R7 quiet while stopped", hits == 0, 1'b1, 600);
            #1;
            check("R7 phase rewound", long_gap, 1'b0, 601);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule